// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block is a synthesizable model of a 2-kbit serial EEPROM that answers a three-wire serial master: a chip select, a serial clock and a data input, plus a data output that comes with its own output-enable so the pad can be tri-stated. All serial inputs are synchronized into the system clock, and the serial clock's rising edges are detected there. The storage is a register file that holds either 128 words of 16 bits or 256 words of 8 bits. A width-select input chooses the organization at run time, and the choice also sets the length of the address field in each command.

Commands cover reading with automatic address advance, writing one location, erasing one location, erasing the whole array, filling the whole array with one value, and turning programming on or off. Every programming command starts a self-timed busy window whose length is a parameter. While that window runs and chip select is high, the data output reports ready or busy. A single 1 bit clocked in during that status phase returns the output to high impedance. The width-select input has no internal default, so a board that wants the 16-bit organization ties it to 1.

Top module: `mw_eeprom`

## Requirements
- R1: `org16`=1 gives 128 words of 16 bits, and `org16`=0 gives 256 bytes. In byte mode, byte address b is the half of word b>>1 chosen by b[0]: 0 selects bits 7:0 and 1 selects bits 15:8.
- R2: Bits are taken on rising `sck` edges while `cs` is high. Zeros before the start bit are skipped. A frame is a start bit of 1, a 2-bit opcode and an address field sent MSB first. The address field is 8 bits in 16-bit mode, whose MSB is ignored, and 9 bits in byte mode, whose MSB is ignored. Dropping `cs` before a frame is complete abandons it with no effect.
- R3: Opcode 10 reads. After the last address bit the output is enabled and shows one 0 bit. Each following `sck` rise then presents the next data bit, MSB first.
- R4: If clocking continues past the end of a word, the next address follows without any gap bit. The address wraps from the top location to 0.
- R5: After reset, programming is locked. Opcode 00 with address field top bits 11 unlocks it, and 00 with top bits 00 locks it again. A locked programming command leaves memory unchanged and starts no busy window.
- R6: Opcode 01 is followed by one data word, MSB first (16 or 8 bits). The location is replaced as a whole when `cs` falls after the complete frame.
- R7: Opcode 11 sets the addressed location to all ones when `cs` falls. The array resets to all ones.
- R8: Opcode 00 with top address bits 10 sets every location to all ones. Opcode 00 with top bits 01, followed by one data word, writes that word to every location.
- R9: An accepted programming command keeps the block busy for `WRITE_CYCLES` clock cycles. While `cs` is high afterwards, `sdo_oe`=1 and `sdo` is 0 when busy and 1 when ready.
- R10: During that status phase, an `sck` rise with `sdi`=1 drives `sdo_oe` low. That bit does not count as a start bit, and the status does not come back.
- R11: While busy, start bits are not accepted, so any command sent in that time is ignored.
- R12: `sdo_oe` is low except during a read and during the status phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock; bits are taken on its rising edge |
| sdi | input | 1 | Serial data into the block |
| org16 | input | 1 | 1 = 128x16 organization, 0 = 256x8 |
| sdo | output | 1 | Serial data out: read data or the ready level |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high impedance |

## Verification
Two events can land in the same system cycle: the clock rise that carries the dummy 1 for status release, and the busy counter reaching zero. The bench sweeps the moment of that release clock across a window of seven cycles centred on the expected end of the busy window, so at least one case falls exactly on the expiry cycle. In every case the output must go to high impedance and stay there when chip select is raised again. A later read must then be accepted and must return the value that was programmed.

// File: rtl/mw_pkg.sv
package mw_pkg;

   typedef enum logic [2:0] {
      WK_NONE,
      WK_WORD,
      WK_ERASE,
      WK_ERAL,
      WK_WRAL
   } wkind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_DATA,
      ST_ARMED,
      ST_WAITLOW,
      ST_READ
   } st_e;

   localparam logic [1:0] OP_EXT   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   localparam logic [1:0] EX_LOCK   = 2'b00;
   localparam logic [1:0] EX_FILL   = 2'b01;
   localparam logic [1:0] EX_CLRALL = 2'b10;
   localparam logic [1:0] EX_UNLOCK = 2'b11;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sck_i,
   input  logic di_i,
   output logic cs_o,
   output logic di_o,
   output logic sck_rise
);
   localparam int W = 3;

   logic [W-1:0] tail;
   logic         sck_prev;

   if (STAGES < 1) begin : g_bad_stages
      $error("mw_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tail <= '0;
         else        tail <= {cs_i, sck_i, di_i};
      end
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= '0;
         else        pipe <= {pipe[STAGES-2:0], {cs_i, sck_i, di_i}};
      end
      assign tail = pipe[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= tail[1];
   end

   assign cs_o     = tail[2];
   assign di_o     = tail[0];
   assign sck_rise = tail[1] & ~sck_prev;

endmodule

// File: rtl/mw_busy.sv
module mw_busy #(
   parameter int CYCLES = 625000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt;

   if (CYCLES < 1) begin : g_bad_cycles
      $error("mw_busy: CYCLES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= CW'(CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   // R9: a start always opens the busy window
   p_busy_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   // R9: the window shrinks by exactly one per cycle
   p_busy_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/mw_array.sv
module mw_array
   import mw_pkg::*;
#(
   parameter int WORDS  = 128,
   parameter int WORD_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 org16,
   input  wkind_e               wr_kind,
   input  logic [$clog2(WORDS):0] wr_addr,
   input  logic [WORD_W-1:0]    wr_data,
   input  logic [$clog2(WORDS):0] rd_addr,
   output logic [WORD_W-1:0]    rd_data
);
   localparam int AW = $clog2(WORDS);
   localparam int HW = WORD_W / 2;

   logic [WORDS*WORD_W-1:0] flat;
   logic [AW-1:0]           wsel;
   logic [AW-1:0]           rsel;
   logic                    fill;
   logic                    ones;
   logic [WORD_W-1:0]       mask;
   logic [WORD_W-1:0]       val;
   logic [WORD_W-1:0]       rword;

   if (WORD_W < 4 || (WORD_W % 2) != 0) begin : g_bad_width
      $error("mw_array: WORD_W must be even and at least 4");
   end
   if (WORDS < 4 || (1 << AW) != WORDS) begin : g_bad_depth
      $error("mw_array: WORDS must be a power of two, at least 4");
   end

   assign fill = (wr_kind == WK_ERAL) || (wr_kind == WK_WRAL);
   assign ones = (wr_kind == WK_ERASE) || (wr_kind == WK_ERAL);
   assign wsel = org16 ? wr_addr[AW-1:0] : wr_addr[AW:1];

   always_comb begin
      if (org16 || fill)   mask = '1;
      else if (wr_addr[0]) mask = {{HW{1'b1}}, {HW{1'b0}}};
      else                 mask = {{HW{1'b0}}, {HW{1'b1}}};
      if (ones)            val = '1;
      else if (org16)      val = wr_data;
      else                 val = {2{wr_data[HW-1:0]}};
   end

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic             hit;
      logic [WORD_W-1:0] q;
      assign hit = (wr_kind != WK_NONE) && (fill || (wsel == AW'(i)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= '1;
         else if (hit) q <= (q & ~mask) | (val & mask);
      end
      assign flat[i*WORD_W +: WORD_W] = q;
   end

   assign rsel  = org16 ? rd_addr[AW-1:0] : rd_addr[AW:1];
   assign rword = flat[rsel*WORD_W +: WORD_W];

   always_comb begin
      if (org16)           rd_data = rword;
      else if (rd_addr[0]) rd_data = {{HW{1'b0}}, rword[WORD_W-1:HW]};
      else                 rd_data = {{HW{1'b0}}, rword[HW-1:0]};
   end

   // R5: contents change only when a programming operation is issued
   p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind == WK_NONE) |=> $stable(flat));

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
   import mw_pkg::*;
#(
   parameter int WORDS        = 128,
   parameter int WORD_W       = 16,
   parameter int WRITE_CYCLES = 625000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sck,
   input  logic sdi,
   input  logic org16,
   output logic sdo,
   output logic sdo_oe
);
   localparam int AW      = $clog2(WORDS);
   localparam int HW      = WORD_W / 2;
   localparam int IW      = $clog2(WORD_W);
   localparam int AB16    = AW + 1;
   localparam int AB8     = AW + 2;
   localparam int CMDW    = 2 + AB8;
   localparam int CNTW    = $clog2(CMDW + WORD_W + 1);
   localparam logic [CNTW-1:0] LAST16 = CNTW'(2 + AB16 - 1);
   localparam logic [CNTW-1:0] LAST8  = CNTW'(2 + AB8 - 1);
   localparam logic [CNTW-1:0] DLAST16 = CNTW'(WORD_W - 1);
   localparam logic [CNTW-1:0] DLAST8  = CNTW'(HW - 1);
   localparam logic [IW:0]     RD16   = (IW+1)'(WORD_W);
   localparam logic [IW:0]     RD8    = (IW+1)'(HW);

   logic cs_s, di_s, sck_rise, busy;

   st_e              st;
   wkind_e           kind_q;
   logic             org_q;
   logic [CMDW-1:0]  cmd_sr;
   logic [CNTW-1:0]  cnt;
   logic [WORD_W-1:0] data_sr;
   logic [AW:0]      addr_q;
   logic             wen_q;
   logic             stat_pend;
   logic             sdo_q;
   logic [IW:0]      rd_cnt;

   logic [CMDW-1:0]  cmd_nx;
   logic [1:0]       op_nx;
   logic [1:0]       ext_nx;
   logic [AW:0]      addr_nx;
   logic [AW:0]      addr_inc;
   logic [CNTW-1:0]  cmd_last;
   logic [CNTW-1:0]  data_last;
   logic [IW-1:0]    rd_idx;
   logic [WORD_W-1:0] rd_data;
   logic             prog_go;
   logic             stat_show;
   wkind_e           wr_kind;

   mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .di_i(sdi),
      .cs_o(cs_s), .di_o(di_s), .sck_rise(sck_rise)
   );

   mw_busy #(.CYCLES(WRITE_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .start(prog_go), .busy(busy)
   );

   mw_array #(.WORDS(WORDS), .WORD_W(WORD_W)) u_array (
      .clk(clk), .rst_n(rst_n), .org16(org_q), .wr_kind(wr_kind),
      .wr_addr(addr_q), .wr_data(data_sr), .rd_addr(addr_q), .rd_data(rd_data)
   );

   // command field decode on the incoming bit
   assign cmd_nx    = {cmd_sr[CMDW-2:0], di_s};
   assign op_nx     = org_q ? cmd_nx[AB16+1:AB16]   : cmd_nx[AB8+1:AB8];
   assign ext_nx    = org_q ? cmd_nx[AB16-1:AB16-2] : cmd_nx[AB8-1:AB8-2];
   assign addr_nx   = org_q ? {1'b0, cmd_nx[AW-1:0]} : cmd_nx[AW:0];
   assign cmd_last  = org_q ? LAST16 : LAST8;
   assign data_last = org_q ? DLAST16 : DLAST8;
   assign addr_inc  = org_q ? {1'b0, addr_q[AW-1:0] + AW'(1)} : addr_q + (AW+1)'(1);
   assign rd_idx    = IW'(rd_cnt - 1'b1);

   assign prog_go   = (st == ST_ARMED) && !cs_s && wen_q;
   assign wr_kind   = prog_go ? kind_q : WK_NONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         kind_q    <= WK_NONE;
         org_q     <= 1'b1;
         cmd_sr    <= '0;
         cnt       <= '0;
         data_sr   <= '0;
         addr_q    <= '0;
         wen_q     <= 1'b0;
         stat_pend <= 1'b0;
         sdo_q     <= 1'b0;
         rd_cnt    <= '0;
      end else begin
         if (prog_go) stat_pend <= 1'b1;
         if (!cs_s) begin
            st <= ST_IDLE;
         end else if (sck_rise) begin
            if (stat_pend) begin
               if (di_s) stat_pend <= 1'b0;
            end else begin
               unique case (st)
                  ST_IDLE: begin
                     if (di_s && !busy) begin
                        st     <= ST_CMD;
                        org_q  <= org16;
                        cnt    <= '0;
                        cmd_sr <= '0;
                     end
                  end
                  ST_CMD: begin
                     cmd_sr <= cmd_nx;
                     cnt    <= cnt + 1'b1;
                     if (cnt == cmd_last) begin
                        addr_q <= addr_nx;
                        cnt    <= '0;
                        unique case (op_nx)
                           OP_READ: begin
                              st     <= ST_READ;
                              sdo_q  <= 1'b0;
                              rd_cnt <= org_q ? RD16 : RD8;
                           end
                           OP_WRITE: begin
                              st     <= ST_DATA;
                              kind_q <= WK_WORD;
                           end
                           OP_ERASE: begin
                              st     <= ST_ARMED;
                              kind_q <= WK_ERASE;
                           end
                           default: begin
                              unique case (ext_nx)
                                 EX_UNLOCK: begin wen_q <= 1'b1; st <= ST_WAITLOW; end
                                 EX_LOCK:   begin wen_q <= 1'b0; st <= ST_WAITLOW; end
                                 EX_CLRALL: begin kind_q <= WK_ERAL; st <= ST_ARMED; end
                                 default:   begin kind_q <= WK_WRAL; st <= ST_DATA; end
                              endcase
                           end
                        endcase
                     end
                  end
                  ST_DATA: begin
                     data_sr <= {data_sr[WORD_W-2:0], di_s};
                     cnt     <= cnt + 1'b1;
                     if (cnt == data_last) st <= ST_ARMED;
                  end
                  ST_READ: begin
                     sdo_q <= rd_data[rd_idx];
                     if (rd_cnt == (IW+1)'(1)) begin
                        addr_q <= addr_inc;
                        rd_cnt <= org_q ? RD16 : RD8;
                     end else begin
                        rd_cnt <= rd_cnt - 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   assign stat_show = stat_pend & cs_s;
   assign sdo_oe    = stat_show | (st == ST_READ);
   assign sdo       = stat_show ? ~busy : sdo_q;

   // R5: a busy window only ever follows an unlocked command
   p_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wen_q));

   // R3: entering a read shows the leading zero bit
   p_dummy_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == ST_READ) |-> (sdo_oe && !sdo));

   // R10: a 1 clocked in during status releases the output
   p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_show && sck_rise && di_s) |=> !sdo_oe);

   // R11: no frame starts while the busy window runs
   p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !stat_pend && st == ST_IDLE) |=> (st == ST_IDLE));

   // R9: a finished window reports ready while status is shown
   p_status_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_show && !busy) |-> (sdo_oe && sdo));

endmodule

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
   localparam int WC   = 300;
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sck = 1'b0, sdi = 1'b0, org16 = 1'b1;
   logic sdo, sdo_oe;

   int tests = 0;
   int fails = 0;
   bit en = 1'b0;
   logic [15:0] mdl [128];

   mw_eeprom #(.WRITE_CYCLES(WC)) dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .sdi(sdi),
      .org16(org16), .sdo(sdo), .sdo_oe(sdo_oe)
   );

   always #4 clk = ~clk;

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] mread(input bit o, input int a);
      logic [15:0] w;
      if (o) return mdl[a & 127];
      w = mdl[(a >> 1) & 127];
      return (a & 1) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
   endfunction

   task automatic mput(input bit o, input int a, input logic [15:0] v);
      if (o) mdl[a & 127] = v;
      else if (a & 1) mdl[(a >> 1) & 127][15:8] = v[7:0];
      else mdl[(a >> 1) & 127][7:0] = v[7:0];
   endtask

   function automatic logic [8:0] afield(input bit o, input int a);
      return o ? {2'b00, 7'(a)} : {1'b0, 8'(a)};
   endfunction

   function automatic logic [8:0] efield(input bit o, input logic [1:0] c);
      return o ? {1'b0, c, 6'b0} : {c, 7'b0};
   endfunction

   task automatic tick(input logic b, output logic o, output logic oe);
      sdi = b;
      repeat (HALF) @(negedge clk);
      o = sdo;
      oe = sdo_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
   endtask

   task automatic send(input logic [31:0] v, input int n);
      logic o, oe;
      for (int i = n - 1; i >= 0; i--) tick(v[i], o, oe);
   endtask

   task automatic begin_frame();
      cs = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic end_frame();
      sck = 1'b0;
      sdi = 1'b0;
      cs = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic cmd(input logic [1:0] op, input logic [8:0] a);
      send(32'd1, 1);
      send({30'd0, op}, 2);
      send({23'd0, a}, org16 ? 8 : 9);
   endtask

   // after cs fell on a programming frame: check status, wait, release
   task automatic prog_wait(input string tag, input bit expect_status);
      int n = 0;
      logic o, oe;
      cs = 1'b1;
      repeat (4) @(negedge clk);
      check({tag, " R9 status enable"}, {31'd0, sdo_oe}, {31'd0, expect_status});
      if (expect_status) begin
         check({tag, " R9 busy level"}, {31'd0, sdo}, 32'd0);
         while (sdo === 1'b0 && n < 2 * WC) begin
            @(negedge clk);
            n++;
         end
         check({tag, " R9 ready level"}, {31'd0, sdo}, 32'd1);
         check({tag, " R9 window length"}, {31'd0, (n > WC - 30) && (n < WC + 10)}, 32'd1);
         tick(1'b1, o, oe);
         repeat (4) @(negedge clk);
         check({tag, " R10 released"}, {31'd0, sdo_oe}, 32'd0);
      end
      end_frame();
   endtask

   task automatic read_chk(input string tag, input logic [8:0] field, input int a, input int n);
      int dw = org16 ? 16 : 8;
      int size = org16 ? 128 : 256;
      logic o, oe;
      logic [15:0] got;
      bit oe_ok = 1'b1;
      begin_frame();
      cmd(2'b10, field);
      tick(1'b0, o, oe);
      check({tag, " R3 leading zero"}, {30'd0, oe, o}, 32'd2);
      for (int k = 0; k < n; k++) begin
         got = '0;
         for (int b = 0; b < dw; b++) begin
            tick(1'b0, o, oe);
            got = {got[14:0], o};
            if (oe !== 1'b1) oe_ok = 1'b0;
         end
         check({tag, k == 0 ? " R3 data" : " R4 next word"}, {16'd0, got},
               {16'd0, mread(org16, (a + k) % size)});
      end
      check({tag, " R12 enable during read"}, {31'd0, oe_ok}, 32'd1);
      end_frame();
   endtask

   task automatic ext_op(input logic [1:0] code);
      begin_frame();
      cmd(2'b00, efield(org16, code));
      end_frame();
      if (code == 2'b11) en = 1'b1;
      if (code == 2'b00) en = 1'b0;
   endtask

   task automatic write_op(input string tag, input int a, input logic [15:0] d);
      begin_frame();
      cmd(2'b01, afield(org16, a));
      send({16'd0, d}, org16 ? 16 : 8);
      end_frame();
      if (en) mput(org16, a, d);
      prog_wait(tag, en);
   endtask

   task automatic erase_op(input string tag, input int a);
      begin_frame();
      cmd(2'b11, afield(org16, a));
      end_frame();
      if (en) mput(org16, a, 16'hFFFF);
      prog_wait(tag, en);
   endtask

   initial begin
      logic o, oe;
      int unsigned seed;
      seed = $urandom(32'h5EED_0042);
      for (int i = 0; i < 128; i++) mdl[i] = 16'hFFFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R12 reset output off", {31'd0, sdo_oe}, 32'd0);

      // R5: locked after reset
      write_op("R5 locked write", 3, 16'h1234);
      read_chk("R5 locked unchanged", afield(1, 3), 3, 1);

      ext_op(2'b11);
      write_op("R6 word write", 5, 16'hA5C3);
      read_chk("R6 word readback", afield(1, 5), 5, 1);

      // R1: byte view of the same word
      org16 = 1'b0;
      read_chk("R1 byte lanes", afield(0, 10), 10, 2);
      write_op("R1 byte write", 255, 16'h005A);
      read_chk("R4 byte wrap", afield(0, 255), 255, 2);
      org16 = 1'b1;
      read_chk("R4 word wrap", afield(1, 127), 127, 2);

      // R2: ignored address MSB and leading zeros
      read_chk("R2 ignored msb", 9'h085, 5, 1);
      begin_frame();
      send(32'd0, 2);
      cmd(2'b10, afield(1, 5));
      tick(1'b0, o, oe);
      check("R2 leading zeros dummy", {30'd0, oe, o}, 32'd2);
      end_frame();

      // R7: single erase in both organizations
      erase_op("R7 word erase", 5);
      read_chk("R7 word erased", afield(1, 5), 5, 1);
      org16 = 1'b0;
      erase_op("R7 byte erase", 255);
      org16 = 1'b1;
      read_chk("R7 byte erased", afield(1, 127), 127, 1);

      // R8: fill and clear all
      org16 = 1'b0;
      begin_frame();
      cmd(2'b00, efield(0, 2'b01));
      send(32'h3C, 8);
      end_frame();
      for (int i = 0; i < 128; i++) mdl[i] = 16'h3C3C;
      prog_wait("R8 fill", 1'b1);
      org16 = 1'b1;
      read_chk("R8 fill readback", afield(1, 77), 77, 2);
      begin_frame();
      cmd(2'b00, efield(1, 2'b10));
      end_frame();
      for (int i = 0; i < 128; i++) mdl[i] = 16'hFFFF;
      prog_wait("R8 clear all", 1'b1);
      read_chk("R8 clear readback", afield(1, 40), 40, 1);

      // R2: abandoned frame
      begin_frame();
      cmd(2'b01, afield(1, 9));
      send(32'hAB, 8);
      end_frame();
      cs = 1'b1;
      repeat (4) @(negedge clk);
      check("R2 abort no status", {31'd0, sdo_oe}, 32'd0);
      end_frame();
      read_chk("R2 abort unchanged", afield(1, 9), 9, 1);

      // R5: relock
      ext_op(2'b00);
      write_op("R5 relocked write", 1, 16'h0F0F);
      read_chk("R5 relocked unchanged", afield(1, 1), 1, 1);
      ext_op(2'b11);

      // R11: command during busy is ignored
      begin_frame();
      cmd(2'b01, afield(1, 2));
      send(32'h1111, 16);
      end_frame();
      mdl[2] = 16'h1111;
      cs = 1'b1;
      repeat (4) @(negedge clk);
      tick(1'b1, o, oe);
      repeat (2) @(negedge clk);
      cmd(2'b10, afield(1, 2));
      tick(1'b0, o, oe);
      check("R11 read ignored while busy", {31'd0, oe}, 32'd0);
      end_frame();
      repeat (WC) @(negedge clk);
      read_chk("R11 later read", afield(1, 2), 2, 1);

      // release clock swept across the end of the busy window
      for (int k = -3; k <= 3; k++) begin
         begin_frame();
         cmd(2'b01, afield(1, 20 + k + 3));
         send({16'd0, 16'(16'hC000 + k + 3)}, 16);
         sck = 1'b0;
         sdi = 1'b0;
         cs = 1'b0;
         mdl[20 + k + 3] = 16'(16'hC000 + k + 3);
         repeat (4) @(negedge clk);
         cs = 1'b1;
         sdi = 1'b1;
         repeat (WC - 3 + k) @(negedge clk);
         sck = 1'b1;
         repeat (6) @(negedge clk);
         check("R10 release at window end", {31'd0, sdo_oe}, 32'd0);
         sck = 1'b0;
         end_frame();
         cs = 1'b1;
         repeat (4) @(negedge clk);
         check("R10 status stays off", {31'd0, sdo_oe}, 32'd0);
         end_frame();
         repeat (10) @(negedge clk);
         read_chk("R9 read after sweep", afield(1, 20 + k + 3), 20 + k + 3, 1);
      end

      // random mix
      for (int it = 0; it < 20; it++) begin
         int a;
         logic [15:0] d;
         org16 = 1'($urandom % 2);
         a = int'($urandom % (org16 ? 128 : 256));
         d = 16'($urandom);
         if (org16 == 1'b0) d[15:8] = 8'h00;
         if (($urandom % 4) == 0) erase_op("R7 random erase", a);
         else write_op("R6 random write", a, d);
         read_chk("R6 random readback", afield(org16, a), a, 1);
         a = int'($urandom % (org16 ? 128 : 256));
         read_chk("R4 random pair", afield(org16, a), a, 2);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule